// File: doc/BRIEF.md
# Bit-Serial Unsigned Adder

This block adds two unsigned operands of a configurable width with a single one-bit full adder, working from the least significant bit upward at one bit per clock. A start pulse captures both operands into shift registers and clears a stored carry bit. On each later cycle the full adder combines the low bits of the two operand registers with the stored carry. The new carry is stored for the next cycle, and the sum bit is shifted into a result register from its top end.

After as many cycles as the operand width, the result register holds the sum in normal bit order and the carry bit holds the carry out. A one-cycle completion flag marks that point. The values then stay put until the next start pulse. The block fits places where adder area matters more than latency. The operand width does not change the amount of adder logic, only the number of cycles an addition takes.

Top module: `serial_adder`

## Requirements
- R1: A synchronous, active-high reset clears the result register, the carry output and the done flag to 0 at the next rising clock edge.
- R2: A clock edge with `start` high captures `in_a` and `in_b`, clears the carry bit and the result register, and leaves `done` low in the following cycle.
- R3: Exactly WIDTH rising edges after the start edge, `sum` equals (`in_a` + `in_b`) modulo 2^WIDTH, with the captured values used.
- R4: At that same point `carry_out` equals bit WIDTH of the full (WIDTH+1)-bit sum of the captured operands.
- R5: `done` is 0 for the first WIDTH-1 cycles after the start edge and is 1 in the cycle that follows the WIDTH-th shift edge.
- R6: `done` stays high for exactly one cycle. After it falls, `sum` and `carry_out` keep their values until the next `start` or reset.
- R7: A `start` pulse during an addition abandons it. The new operands are captured, and the result and `done` follow R3 to R5 counted from the new start edge.
- R8: Changes on `in_a` and `in_b` while `start` is low have no effect on the result.
- R9: Sum bits enter the result register at bit WIDTH-1 and shift toward bit 0. After the first shift edge, `sum[WIDTH-1]` equals bit 0 of `in_a` XOR bit 0 of `in_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin an addition |
| in_a | input | WIDTH | First operand, sampled only with start |
| in_b | input | WIDTH | Second operand, sampled only with start |
| sum | output | WIDTH | Result register |
| carry_out | output | 1 | Stored carry bit; final carry out when the addition completes |
| done | output | 1 | One-cycle completion pulse |

## Verification
The operand pairs are chosen to separate the carry paths. A pair with no carries (10+5) exposes errors in bit order or in the shift count. A pair with a carry that ripples through every position (15+1) exercises the stored carry across all cycles and the final carry out. Equal, all-ones operands (15+15) and a small wrapping pair (9+9) test carry generation at both ends of the word. A zero addition that follows an addition ending with a carry shows whether start really clears the carry bit. A start in the middle of an addition and a reset in the middle of an addition show that no stale state carries over. The operand inputs are toggled during each addition to show that they are sampled only with start.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    localparam int unsigned BSA_DEFAULT_WIDTH = 4;

    typedef struct packed {
        logic s;
        logic c;
    } fa_res_t;

    function automatic fa_res_t fa_eval(input logic x, input logic y, input logic ci);
        fa_res_t r;
        r.s = x ^ y ^ ci;
        r.c = (x & y) | (ci & (x ^ y));
        return r;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bsa_full_adder.sv
module bsa_full_adder
    import bsa_pkg::*;
(
    input  logic    x,
    input  logic    y,
    input  logic    ci,
    output fa_res_t res
);

    always_comb begin
        res = fa_eval(x, y, ci);
    end

endmodule

// File: rtl/bsa_shreg.sv
module bsa_shreg #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             shift,
    input  logic             sin,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] shifted;

    generate
        if (WIDTH == 1) begin : g_one
            assign shifted = sin;
        end else begin : g_many
            assign shifted = {sin, q[WIDTH-1:1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift)
            q <= shifted;
    end

    // R8: with no load and no shift the contents hold
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(q));

endmodule

// File: rtl/bsa_seq.sv
module bsa_seq
    import bsa_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic shift_en,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = cnt_bits(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
            done <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign shift_en = busy & ~start;

    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: done only follows a cycle of shifting
    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> !busy);

    // R5: the counter never runs past the last shift
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST));

endmodule

// File: rtl/serial_adder.sv
module serial_adder
    import bsa_pkg::*;
#(
    parameter int unsigned WIDTH = BSA_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             done
);

    localparam int unsigned NOPS = 2;

    logic [WIDTH-1:0] op_in [NOPS];
    logic [WIDTH-1:0] op_q  [NOPS];
    logic             shift_en;
    logic             busy;
    logic             carry_q;
    fa_res_t          fa;

    assign op_in[0] = in_a;
    assign op_in[1] = in_b;

    generate
        for (genvar k = 0; k < NOPS; k++) begin : g_op
            bsa_shreg #(.WIDTH(WIDTH)) u_op (
                .clk   (clk),
                .rst   (rst),
                .load  (start),
                .din   (op_in[k]),
                .shift (shift_en),
                .sin   (1'b0),
                .q     (op_q[k])
            );
        end
    endgenerate

    bsa_full_adder u_fa (
        .x   (op_q[0][0]),
        .y   (op_q[1][0]),
        .ci  (carry_q),
        .res (fa)
    );

    bsa_shreg #(.WIDTH(WIDTH)) u_res (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .din   ('0),
        .shift (shift_en),
        .sin   (fa.s),
        .q     (sum)
    );

    bsa_seq #(.WIDTH(WIDTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .shift_en (shift_en),
        .busy     (busy),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst || start)
            carry_q <= 1'b0;
        else if (shift_en)
            carry_q <= fa.c;
    end

    assign carry_out = carry_q;

    // R2: a start edge clears carry, result and done
    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> (!carry_out && !done && (sum == '0)));

    // R6: outside an addition the visible result does not move
    p_result_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(sum) && $stable(carry_out)));

    // R1: reset leaves everything cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!done && !carry_out && (sum == '0)));

endmodule

// File: tb/serial_adder_test.sv
module serial_adder_test;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic [W-1:0] sum;
    logic         carry_out;
    logic         done;

    int checks = 0;
    int errors = 0;

    serial_adder #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .in_a      (in_a),
        .in_b      (in_b),
        .sum       (sum),
        .carry_out (carry_out),
        .done      (done)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic kick(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_a  = a;
        in_b  = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        in_a  = ~a;
        in_b  = ~b;
        chk(done == 1'b0 && carry_out == 1'b0 && sum == '0, "R2 start clears", {sum, carry_out, done}, 0);
    endtask

    // Full addition: start, follow shifts, check completion and hold.
    task automatic t_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] full;
        logic [W-1:0] held;
        full = {1'b0, a} + {1'b0, b};
        kick(a, b);
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R5 done early", done, 0);
            if (i == 1)
                chk(sum[W-1] == (a[0] ^ b[0]), "R9 first bit at top", sum[W-1], a[0] ^ b[0]);
        end
        @(negedge clk);
        chk(done == 1'b1, "R5 done on time", done, 1);
        chk(sum == full[W-1:0], "R3 sum R8 ignored inputs", sum, full[W-1:0]);
        chk(carry_out == full[W], "R4 carry out", carry_out, full[W]);
        held = sum;
        in_a = a ^ 4'h5;
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", done, 0);
        @(negedge clk);
        chk(sum == held && carry_out == full[W], "R6 hold", sum, held);
    endtask

    // Start in the middle of an addition.
    task automatic t_restart();
        logic [W:0] full;
        kick(4'hF, 4'hF);
        @(negedge clk);
        @(negedge clk);
        full = {1'b0, 4'h1} + {1'b0, 4'h6};
        kick(4'h1, 4'h6);
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R7 no early done", done, 0);
        end
        @(negedge clk);
        chk(done == 1'b1, "R7 done", done, 1);
        chk(sum == full[W-1:0] && carry_out == full[W], "R7 result", {carry_out, sum}, full);
    endtask

    // Reset in the middle of an addition.
    task automatic t_reset_mid();
        kick(4'hF, 4'h1);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(sum == '0 && carry_out == 1'b0 && done == 1'b0, "R1 mid reset", {sum, carry_out, done}, 0);
        for (int i = 0; i < W + 1; i++) begin
            @(negedge clk);
            chk(done == 1'b0, "R1 stays idle", done, 0);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(sum == '0 && carry_out == 1'b0 && done == 1'b0, "R1 reset state", {sum, carry_out, done}, 0);
        rst = 1'b0;
        t_add(4'd3, 4'd5);
        t_add(4'd15, 4'd1);
        t_add(4'd0, 4'd0);
        t_add(4'd15, 4'd15);
        t_add(4'd10, 4'd5);
        t_add(4'd9, 4'd9);
        t_restart();
        t_reset_mid();
        t_add(4'd7, 4'd12);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule